// File: doc/BRIEF.md
# Decimal Digit Counter with Derived Upper-Bit Enables

This block is a single-digit decimal up-counter that counts in 8421 binary-coded decimal. Its least significant bit advances on every enabled master clock edge. The three upper bits load a new value only on the enabled edges where the least significant bit is 1 beforehand, which are the edges where it falls from 1 to 0. This enable stands in for a gated per-bit clock. Every flip-flop stays on the one master clock, so the derived trigger adds no skew.

The upper bits are idle in every other cycle. Their next-state logic can therefore treat states with bit 0 clear as don't-care, and it comes out much smaller than the logic of a counter that evaluates every bit on every edge. A one-cycle carry output marks the cycle whose edge wraps the digit from nine back to zero. A cascade of digits or a divide-by-ten stage can use it as its enable.

Top module: `bcd_gated_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0000 after that edge, whatever `count_en` is. `carry` is 0 in any cycle where `rst` is high.
- R2: When `count_en` is low at a rising edge (and `rst` is low), the count keeps its value after that edge.
- R3: When `count_en` is high at a rising edge (and `rst` is low), `count[0]` takes the inverse of its previous value after that edge.
- R4: Bits `count[3:1]` change only across a rising edge where `count_en` was high and `count[0]` was 1 before the edge.
- R5: With `count_en` high, the count steps through 0,1,2,...,9 in 8421 coding (bit 3 most significant), one step per edge.
- R6: `carry` is 1 exactly in the cycles where the count is 1001, `count_en` is high and `rst` is low. The output is combinational, so it is valid in the same cycle as those inputs.
- R7: An enabled edge at 1001 yields 0000. Bit 3 clears, and bits 1 and 2 stay at 0.
- R8: After the first reset the count never holds a value above 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Count enable; the digit advances on enabled edges |
| count | output | 4 | Current digit, 8421 BCD, bit 3 most significant |
| carry | output | 1 | High in the cycle whose edge wraps 1001 to 0000 |

## Verification
The bench runs directed passes through the 1001-to-0000 wrap, a hold at 1001 with the enable low, and a reset applied with the enable high. It then runs long random stretches with the enable and reset toggling, and compares every cycle against a modulo-ten reference.

Each error the bench targets shows up in a specific way:
- An enable derived from the wrong bit or the wrong polarity moves the upper bits on edges where bit 0 was 0. The per-edge idle-bit check catches this.
- A wrap decoded wrongly lands on 1010 or leaves bit 1 set.
- A carry that ignores the enable pulses while the digit holds at nine.
- A reset given a lower priority than the enable lets the digit step instead of clearing.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam int UPPER_W = DIGIT_W - 1;
    localparam logic [DIGIT_W-1:0] DIGIT_LAST = DIGIT_W'(9);
    localparam logic [DIGIT_W-1:0] DIGIT_ZERO = '0;

    // Digit split into the always-clocked bit and the enabled upper bits.
    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic               lsb;
    } digit_t;

    // Next upper bits, valid only when the lsb is 1 before the edge.
    // States with lsb = 0 never load, so they are treated as don't-care.
    // u[0] is weight 2, u[1] weight 4, u[2] weight 8.
    function automatic logic [UPPER_W-1:0] upper_advance(input logic [UPPER_W-1:0] u);
        logic [UPPER_W-1:0] n;
        n[0] = ~u[0] & ~u[2];
        n[1] = u[1] ^ u[0];
        n[2] = u[1] & u[0];
        return n;
    endfunction

endpackage

// File: rtl/bcd_lsb_stage.sv
module bcd_lsb_stage (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic lsb_q
);
    always_ff @(posedge clk) begin
        if (rst)
            lsb_q <= 1'b0;
        else if (step)
            lsb_q <= ~lsb_q;
    end
endmodule

// File: rtl/bcd_upper_stage.sv
module bcd_upper_stage
    import bcd_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    output logic [UPPER_W-1:0] upper_q
);
    logic [UPPER_W-1:0] upper_next;

    always_comb upper_next = upper_advance(upper_q);

    always_ff @(posedge clk) begin
        if (rst)
            upper_q <= '0;
        else if (load)
            upper_q <= upper_next;
    end
endmodule

// File: rtl/bcd_trigger.sv
module bcd_trigger
    import bcd_cnt_pkg::*;
(
    input  logic   rst,
    input  logic   count_en,
    input  digit_t cur,
    output logic   upper_load,
    output logic   wrap_pulse
);
    // Derived trigger: an enabled edge with lsb = 1 is a falling lsb edge.
    always_comb begin
        upper_load = count_en & cur.lsb;
        wrap_pulse = ~rst & count_en & ({cur.upper, cur.lsb} == DIGIT_LAST);
    end
endmodule

// File: rtl/bcd_gated_counter.sv
module bcd_gated_counter
    import bcd_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               count_en,
    output logic [DIGIT_W-1:0] count,
    output logic               carry
);
    digit_t digit;
    logic   upper_load;

    bcd_lsb_stage i_lsb (
        .clk   (clk),
        .rst   (rst),
        .step  (count_en),
        .lsb_q (digit.lsb)
    );

    bcd_upper_stage i_upper (
        .clk     (clk),
        .rst     (rst),
        .load    (upper_load),
        .upper_q (digit.upper)
    );

    bcd_trigger i_trig (
        .rst        (rst),
        .count_en   (count_en),
        .cur        (digit),
        .upper_load (upper_load),
        .wrap_pulse (carry)
    );

    assign count = {digit.upper, digit.lsb};
endmodule

// File: rtl/bcd_gated_counter_chk.sv
module bcd_gated_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       count_en,
    input logic [3:0] count,
    input logic       carry
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b1;
        else if (armed !== 1'b1)
            armed <= 1'b0;
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (count == 4'd0));

    p_reset_no_carry_r1: assert property (@(posedge clk)
        rst |-> !carry);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        !count_en |=> $stable(count));

    p_lsb_toggle_r3: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        count_en |=> (count[0] != $past(count[0])));

    p_upper_idle_r4: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        !(count_en && count[0]) |=> $stable(count[3:1]));

    p_carry_wraps_r6: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        carry |=> (count == 4'd0));

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (count_en && count == 4'd9) |=> (count == 4'd0));

    p_in_range_r8: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        count <= 4'd9);
endmodule

bind bcd_gated_counter bcd_gated_counter_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .count    (count),
    .carry    (carry)
);

// File: tb/test_bcd_gated_counter.sv
module test_bcd_gated_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       count_en = 1'b0;
    logic [3:0] count;
    logic       carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] ref_cnt = 4'd0;

    bcd_gated_counter i_bcd_gated_counter (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .count    (count),
        .carry    (carry)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] ref_next(input logic [3:0] c, input logic r, input logic e);
        if (r) return 4'd0;
        if (!e) return c;
        return (c == 4'd9) ? 4'd0 : c + 4'd1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic r, input logic e);
        logic [3:0] prev;
        logic exp_carry;
        @(negedge clk);
        rst = r;
        count_en = e;
        #1;
        exp_carry = !r && e && (ref_cnt == 4'd9);
        check(carry === exp_carry, r ? "R1 carry in reset" : "R6 carry", int'(carry), int'(exp_carry));
        prev = count;
        @(posedge clk);
        #1;
        ref_cnt = ref_next(ref_cnt, r, e);
        if (r)
            check(count === 4'd0, "R1 reset value", int'(count), 0);
        else if (!e)
            check(count === prev, "R2 hold", int'(count), int'(prev));
        else begin
            check(count === ref_cnt, "R5 sequence", int'(count), int'(ref_cnt));
            check(count[0] === ~prev[0], "R3 lsb toggle", int'(count[0]), int'(~prev[0]));
            if (prev == 4'd9)
                check(count === 4'd0, "R7 wrap", int'(count), 0);
        end
        if (!(e && prev[0]) && !r)
            check(count[3:1] === prev[3:1], "R4 upper idle", int'(count[3:1]), int'(prev[3:1]));
        check(count <= 4'd9, "R8 range", int'(count), 9);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, with the enable high as well
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        // R5, R7: two full passes through the wrap
        for (int i = 0; i < 25; i++) cycle(1'b0, 1'b1);
        // Walk to 9, then hold there with the enable low (R2, R6 carry stays low)
        while (ref_cnt != 4'd9) cycle(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b1);
        // R1: reset in the middle of a count overrides the enable
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        // Random enable and occasional reset
        for (int i = 0; i < 3000; i++)
            cycle(($urandom % 97) == 0, ($urandom % 4) != 0);
        // Sparse enables
        for (int i = 0; i < 500; i++)
            cycle(1'b0, ($urandom % 5) == 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule